// File: doc/BRIEF.md
# DDS Tuning Word Serial Loader

This block turns a 24-bit output frequency in hertz into the 32-bit phase-increment word of a direct digital synthesizer and shifts that word into the synthesizer over a three-wire serial link. The three wires are data, clock and an active-low frame sync. A one-cycle `start` pulse takes an atomic snapshot of `freq_in`. The snapshot drives a 32-step shift-add multiply against a fixed calibration constant, which is 2^56 divided by the synthesizer clock (0xABCC7712 for 25 MHz). Five 16-bit frames then carry the word to the synthesizer. The snapshot also stays on `freq_copy`, so a display converter can read it.

The synthesizer has two frequency register banks. Each update writes the bank that is not in use: first four staging and load frames, then a fifth frame that switches the output to that bank. A partial write therefore never reaches the output. Out of reset the block sends a fixed three-frame wake-up sequence without being asked.

The sequencer has six states. INIT_GO and INIT_WAIT send the wake-up frames one at a time. IDLE waits for `start`. MULT waits for the multiplier. LOAD_GO and LOAD_WAIT send the update frames. The transitions are:
- reset leads to INIT_GO.
- INIT_GO leads to INIT_WAIT.
- When a frame finishes, INIT_WAIT goes to INIT_GO, or to IDLE after the third frame.
- IDLE goes to MULT on `start`.
- MULT goes to LOAD_GO when the product is ready.
- LOAD_GO leads to LOAD_WAIT.
- When a frame finishes, LOAD_WAIT goes to LOAD_GO, or to IDLE after the fifth frame, at which point the target bank flips.

The frame shifter has its own five states: SR_IDLE, SR_LOW, SR_HIGH, SR_TAIL and SR_GAP.

Top module: `dds_word_loader`

## Requirements
- R1: After reset, three frames go out in this order: 0xF800, 0xB000, 0xC000. `busy` stays high until the last of them has ended, and then the block idles.
- R2: When no frame is in flight, sync is high and the serial clock is low. The serial clock never rises while sync is high.
- R3: Each frame has exactly 16 rising serial-clock edges with sync low, most significant bit first. Sync falls before the first rising edge and rises after the last one. Data holds steady for as long as the serial clock is high.
- R4: Every high phase of the serial clock lasts `HALF_DIV` system clocks.
- R5: A `start` pulse seen while `busy` is low loads `freq_in` into `freq_copy` and raises `busy` on the next clock edge.
- R6: A `start` seen while `busy` is high is ignored. That includes the last busy cycle and the whole wake-up sequence. `freq_copy` keeps its value and no extra frames are sent.
- R7: The tuning word equals floor(freq × CAL / 2^24). It is built in 32 shift-add steps, one per calibration bit, and each step adds the frequency shifted left by 8 bits. Byte k of the word (k = 0 is the least significant) is the low byte of update frame k.
- R8: An update sends five frames. The high bytes of frames 0 to 3 are 0x30|B|k when k is even and 0x20|B|k when k is odd, where B = 0x04 for bank 1 and 0 for bank 0. The fifth frame is 0x5000 for bank 0 or 0x5800 for bank 1.
- R9: The first update after reset targets bank 1, and the bank alternates on every update after that.
- R10: `busy` falls one sync-high gap after the fifth frame ends, and exactly five frames are sent per update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to load a new frequency |
| freq_in | input | 24 | Frequency in hertz |
| busy | output | 1 | High during the wake-up sequence and during an update |
| freq_copy | output | 24 | Snapshot of the last accepted frequency |
| dds_sdata | output | 1 | Serial data to the synthesizer |
| dds_sclk | output | 1 | Serial clock to the synthesizer |
| dds_sync_n | output | 1 | Active-low frame sync |

## Verification
The risky coincidence is a new request arriving in the same cycle as the end of the last frame, which is also the cycle in which the sequencer returns to IDLE. The bench provokes this by holding `start` high, with a different frequency, for the whole busy window. It releases `start` only after it has seen `busy` low, so the request is present on the edge where the sequencer leaves LOAD_WAIT. The same stress is applied during the wake-up sequence. The bench judges the result from the ports: `freq_copy` must keep its earlier value and exactly five frames must have been logged. Random frequencies, plus the corner values 0, 0xFFFFFF and 6 MHz, are checked against a bench-side 64-bit product.

// File: rtl/dds_ldr_pkg.sv
package dds_ldr_pkg;

    localparam int WORD_W      = 32;
    localparam int FRAME_W     = 16;
    localparam int INIT_FRAMES = 3;
    localparam int LOAD_FRAMES = 5;

    typedef enum logic [2:0] {
        T_INIT_GO,
        T_INIT_WAIT,
        T_IDLE,
        T_MULT,
        T_LOAD_GO,
        T_LOAD_WAIT
    } seq_state_t;

    typedef enum logic [2:0] {
        SR_IDLE,
        SR_LOW,
        SR_HIGH,
        SR_TAIL,
        SR_GAP
    } ser_state_t;

    // wake-up sequence: sleep+reset+clear, then sync/source select, then release
    function automatic logic [FRAME_W-1:0] init_frame(input logic [2:0] idx);
        logic [7:0] hi;
        unique case (idx)
            3'd0:    hi = 8'hF8;
            3'd1:    hi = 8'hB0;
            default: hi = 8'hC0;
        endcase
        return {hi, 8'h00};
    endfunction

    // staged load frames (even index = defer, odd = commit pair), then bank select
    function automatic logic [FRAME_W-1:0] load_frame(input logic [2:0]        idx,
                                                      input logic              bank,
                                                      input logic [WORD_W-1:0] word);
        logic [7:0] hi;
        logic [7:0] lo;
        if (idx == 3'd4) begin
            hi = bank ? 8'h58 : 8'h50;
            lo = 8'h00;
        end else begin
            hi = {3'b001, ~idx[0], 1'b0, bank, idx[1:0]};
            lo = word[8*idx[1:0] +: 8];
        end
        return {hi, lo};
    endfunction

endpackage

// File: rtl/dds_mult.sv
module dds_mult #(
    parameter int FREQ_W    = 24,
    parameter int CAL_W     = 32,
    parameter int PRE_SHIFT = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [FREQ_W-1:0] freq,
    input  logic [CAL_W-1:0]  cal,
    output logic              done,
    output logic [CAL_W-1:0]  word
);

    localparam int CNT_W = $clog2(CAL_W);

    logic [CAL_W-1:0] acc;
    logic [CAL_W-1:0] cal_sh;
    logic [CAL_W-1:0] addend;
    logic [CNT_W-1:0] cnt;
    logic             running;
    logic [CAL_W:0]   sum;

    always_comb begin
        sum = {1'b0, acc} + (cal_sh[0] ? {1'b0, addend} : '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc     <= '0;
            cal_sh  <= '0;
            addend  <= '0;
            cnt     <= '0;
            running <= 1'b0;
            done    <= 1'b0;
        end else if (go) begin
            acc     <= '0;
            cal_sh  <= cal;
            addend  <= CAL_W'({freq, {PRE_SHIFT{1'b0}}});
            cnt     <= '0;
            running <= 1'b1;
            done    <= 1'b0;
        end else if (running) begin
            acc    <= sum[CAL_W:1];
            cal_sh <= cal_sh >> 1;
            cnt    <= cnt + 1'b1;
            if (cnt == CNT_W'(CAL_W - 1)) begin
                running <= 1'b0;
                done    <= 1'b1;
            end
        end else begin
            done <= 1'b0;
        end
    end

    assign word = acc;

    // R7: the product is flagged ready only as the step loop ends
    a_r7_done_after_run: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(running) && !running);

endmodule

// File: rtl/dds_frame_tx.sv
module dds_frame_tx #(
    parameter int FRAME_W  = 16,
    parameter int HALF_DIV = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               go,
    input  logic [FRAME_W-1:0] frame,
    output logic               sdata,
    output logic               sclk,
    output logic               sync_n,
    output logic               done
);
    import dds_ldr_pkg::*;

    localparam int TICK_W = (HALF_DIV < 2) ? 1 : $clog2(HALF_DIV);
    localparam int BIT_W  = $clog2(FRAME_W);

    ser_state_t         st, st_nxt;
    logic [TICK_W-1:0]  tick;
    logic [BIT_W-1:0]   bitcnt;
    logic [FRAME_W-1:0] shreg;
    logic               half_end;
    logic               last_bit;

    assign half_end = (tick == TICK_W'(HALF_DIV - 1));
    assign last_bit = (bitcnt == BIT_W'(FRAME_W - 1));

    always_comb begin
        st_nxt = st;
        unique case (st)
            SR_IDLE: if (go)       st_nxt = SR_LOW;
            SR_LOW:  if (half_end) st_nxt = SR_HIGH;
            SR_HIGH: if (half_end) st_nxt = last_bit ? SR_TAIL : SR_LOW;
            SR_TAIL: if (half_end) st_nxt = SR_GAP;
            SR_GAP:  if (half_end) st_nxt = SR_IDLE;
            default:               st_nxt = SR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st     <= SR_IDLE;
            tick   <= '0;
            bitcnt <= '0;
            shreg  <= '0;
        end else begin
            st <= st_nxt;
            if (st == SR_IDLE || half_end) tick <= '0;
            else                           tick <= tick + 1'b1;
            if (st == SR_IDLE) begin
                bitcnt <= '0;
                if (go) shreg <= frame;
            end else if (st == SR_HIGH && half_end && !last_bit) begin
                bitcnt <= bitcnt + 1'b1;
                shreg  <= {shreg[FRAME_W-2:0], 1'b0};
            end
        end
    end

    always_comb begin
        sync_n = (st == SR_IDLE) || (st == SR_GAP);
        sclk   = (st == SR_HIGH);
        sdata  = (st == SR_LOW || st == SR_HIGH) ? shreg[FRAME_W-1] : 1'b0;
        done   = (st == SR_GAP) && half_end;
    end

    // R2: serial clock only pulses inside a frame
    a_r2_sclk_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> !sync_n);

    // R3: data holds while the serial clock is high
    a_r3_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(sdata));

endmodule

// File: rtl/dds_word_loader.sv
module dds_word_loader #(
    parameter int          FREQ_W    = 24,
    parameter int          PRE_SHIFT = 8,
    parameter int          HALF_DIV  = 2,
    parameter logic [31:0] CAL_CONST = 32'hABCC7712
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [FREQ_W-1:0] freq_in,
    output logic              busy,
    output logic [FREQ_W-1:0] freq_copy,
    output logic              dds_sdata,
    output logic              dds_sclk,
    output logic              dds_sync_n
);
    import dds_ldr_pkg::*;

    seq_state_t          state, state_nxt;
    logic [2:0]          idx;
    logic                bank;
    logic                mult_go;
    logic                mult_done;
    logic [WORD_W-1:0]   word;
    logic                ser_go;
    logic                ser_done;
    logic [FRAME_W-1:0]  ser_frame;

    // ---- state register ----
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= T_INIT_GO;
        else        state <= state_nxt;
    end

    // ---- next state ----
    always_comb begin
        state_nxt = state;
        unique case (state)
            T_INIT_GO:   state_nxt = T_INIT_WAIT;
            T_INIT_WAIT: if (ser_done)
                             state_nxt = (idx == 3'(INIT_FRAMES - 1)) ? T_IDLE : T_INIT_GO;
            T_IDLE:      if (start) state_nxt = T_MULT;
            T_MULT:      if (mult_done) state_nxt = T_LOAD_GO;
            T_LOAD_GO:   state_nxt = T_LOAD_WAIT;
            T_LOAD_WAIT: if (ser_done)
                             state_nxt = (idx == 3'(LOAD_FRAMES - 1)) ? T_IDLE : T_LOAD_GO;
            default:     state_nxt = T_IDLE;
        endcase
    end

    // ---- datapath registers ----
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx       <= '0;
            bank      <= 1'b1;
            freq_copy <= '0;
        end else begin
            if (state == T_IDLE && start) freq_copy <= freq_in;
            if (state == T_MULT) idx <= '0;
            if ((state == T_INIT_WAIT || state == T_LOAD_WAIT) && ser_done) begin
                if (state_nxt == T_IDLE) idx <= '0;
                else                     idx <= idx + 1'b1;
            end
            if (state == T_LOAD_WAIT && ser_done && state_nxt == T_IDLE) bank <= ~bank;
        end
    end

    // ---- outputs ----
    always_comb begin
        busy      = (state != T_IDLE);
        mult_go   = (state == T_IDLE) && start;
        ser_go    = (state == T_INIT_GO) || (state == T_LOAD_GO);
        ser_frame = (state == T_INIT_GO) ? init_frame(idx) : load_frame(idx, bank, word);
    end

    dds_mult #(
        .FREQ_W    (FREQ_W),
        .CAL_W     (WORD_W),
        .PRE_SHIFT (PRE_SHIFT)
    ) u_mult (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (mult_go),
        .freq  (freq_in),
        .cal   (CAL_CONST),
        .done  (mult_done),
        .word  (word)
    );

    dds_frame_tx #(
        .FRAME_W  (FRAME_W),
        .HALF_DIV (HALF_DIV)
    ) u_tx (
        .clk    (clk),
        .rst_n  (rst_n),
        .go     (ser_go),
        .frame  (ser_frame),
        .sdata  (dds_sdata),
        .sclk   (dds_sclk),
        .sync_n (dds_sync_n),
        .done   (ser_done)
    );

    // R2: the link rests with sync high and clock low while idle
    a_r2_sync_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state == T_IDLE) |-> (dds_sync_n && !dds_sclk));

    // R5: an accepted request raises busy on the next edge
    a_r5_busy_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R6: a request during busy leaves the snapshot alone
    a_r6_hold_copy: assert property (@(posedge clk) disable iff (!rst_n)
        (start && busy) |=> $stable(freq_copy));

    // R7: the multiplier reports completion only while the sequencer waits for it
    a_r7_mult_in_state: assert property (@(posedge clk) disable iff (!rst_n)
        mult_done |-> (state == T_MULT));

endmodule

// File: tb/dds_word_loader_bench.sv
`timescale 1ns/1ps
module dds_word_loader_bench;

    localparam int          HALF   = 2;
    localparam logic [31:0] CAL    = 32'hABCC7712;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [23:0] freq_in = '0;
    logic        busy;
    logic [23:0] freq_copy;
    logic        dds_sdata, dds_sclk, dds_sync_n;

    int n_tests = 0;
    int n_fail  = 0;

    logic [15:0] fr_log [0:511];
    int          fr_n = 0;
    logic        exp_bank = 1'b1;

    always #2.5 clk = ~clk;

    dds_word_loader #(.HALF_DIV(HALF), .CAL_CONST(CAL)) u_dds_word_loader (
        .clk(clk), .rst_n(rst_n), .start(start), .freq_in(freq_in),
        .busy(busy), .freq_copy(freq_copy),
        .dds_sdata(dds_sdata), .dds_sclk(dds_sclk), .dds_sync_n(dds_sync_n)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_word(input logic [23:0] f);
        logic [63:0] p;
        p = 64'(f) * 64'(CAL);
        return p[55:24];
    endfunction

    function automatic logic [15:0] exp_frame(input int k, input logic b, input logic [31:0] w);
        logic [7:0] hi;
        if (k == 4) return {(b ? 8'h58 : 8'h50), 8'h00};
        hi = ((k % 2 == 0) ? 8'h30 : 8'h20) | (b ? 8'h04 : 8'h00) | 8'(k);
        return {hi, w[8*k +: 8]};
    endfunction

    // serial receiver model, sampled mid-cycle
    logic        prev_sclk = 1'b0, prev_sync = 1'b1, held = 1'b0;
    logic [15:0] rx_sh = '0;
    int          rx_bits = 0, hi_len = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (dds_sclk && dds_sync_n)
                check(0, "R2", "clock high with sync high", 1, 0);
            if (!dds_sync_n) begin
                if (dds_sclk && !prev_sclk) begin
                    rx_sh   = {rx_sh[14:0], dds_sdata};
                    rx_bits = rx_bits + 1;
                    hi_len  = 1;
                    held    = dds_sdata;
                end else if (dds_sclk) begin
                    hi_len = hi_len + 1;
                    if (dds_sdata != held) check(0, "R3", "data moved while clock high", dds_sdata, held);
                end
                if (!dds_sclk && prev_sclk)
                    check(hi_len == HALF, "R4", "clock high length", hi_len, HALF);
            end
            if (dds_sync_n && !prev_sync) begin
                check(rx_bits == 16, "R3", "bits per frame", rx_bits, 16);
                if (fr_n < 512) fr_log[fr_n] = rx_sh;
                fr_n    = fr_n + 1;
                rx_bits = 0;
            end
            prev_sclk = dds_sclk;
            prev_sync = dds_sync_n;
        end
    end

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic do_update(input logic [23:0] f, input bit stress);
        int          base;
        logic [31:0] w;
        wait_idle();
        base = fr_n;
        @(negedge clk);
        start   = 1'b1;
        freq_in = f;
        @(negedge clk);
        check(busy == 1'b1, "R5", "busy after start", busy, 1);
        check(freq_copy == f, "R5", "snapshot", freq_copy, f);
        if (stress) begin
            freq_in = ~f;           // held through the final busy edge
            while (busy) @(negedge clk);
            start = 1'b0;
            check(freq_copy == f, "R6", "snapshot after start held in busy", freq_copy, f);
        end else begin
            start = 1'b0;
            wait_idle();
        end
        check(fr_n - base == 5, "R10", "frames per update", fr_n - base, 5);
        w = exp_word(f);
        for (int k = 0; k < 5; k++) begin
            logic [15:0] e;
            e = exp_frame(k, exp_bank, w);
            if (k < 4) begin
                check(fr_log[base+k][7:0] == e[7:0], "R7", "word byte", fr_log[base+k][7:0], e[7:0]);
                check(fr_log[base+k][15:8] == e[15:8], "R8", "command byte", fr_log[base+k][15:8], e[15:8]);
            end else begin
                check(fr_log[base+k] == e, "R9", "bank select frame", fr_log[base+k], e);
            end
        end
        exp_bank = ~exp_bank;
    endtask

    initial begin
        logic [31:0] seed_sink;
        seed_sink = $urandom(32'd20240611);
        repeat (4) @(negedge clk);
        check(dds_sync_n == 1'b1 && dds_sclk == 1'b0, "R2", "link at reset",
              {dds_sync_n, dds_sclk}, 2'b10);
        check(freq_copy == 24'd0, "R1", "snapshot at reset", freq_copy, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 1'b1, "R1", "busy during wake-up", busy, 1);
        start   = 1'b1;          // R6: ignored throughout the wake-up sequence
        freq_in = 24'h123456;
        while (busy) @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        check(fr_n == 3, "R1", "wake-up frame count", fr_n, 3);
        check(fr_log[0] == 16'hF800, "R1", "wake-up frame 0", fr_log[0], 16'hF800);
        check(fr_log[1] == 16'hB000, "R1", "wake-up frame 1", fr_log[1], 16'hB000);
        check(fr_log[2] == 16'hC000, "R1", "wake-up frame 2", fr_log[2], 16'hC000);
        check(freq_copy == 24'd0, "R6", "start during wake-up ignored", freq_copy, 0);
        check(busy == 1'b0, "R2", "idle after wake-up", busy, 0);

        do_update(24'd135700, 0);
        do_update(24'd0, 0);
        do_update(24'hFFFFFF, 0);
        do_update(24'd6000000, 1);
        for (int i = 0; i < 12; i++) begin
            do_update(24'($urandom), (i % 3) == 0);
        end
        do_update(24'h000001, 1);

        repeat (10) @(negedge clk);
        check(busy == 1'b0 && dds_sync_n == 1'b1, "R10", "final idle", {busy, dds_sync_n}, 2'b01);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule